// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare and Sub-Second Tick

This block keeps wall time as a 32-bit count of seconds. The design runs on the system clock. A slow strobe, nominally 32.768 kHz and one system clock wide, drives a binary prescaler. When the prescaler wraps it makes a one-second step that advances the count. A lower stage of the same prescaler gives a periodic tick, 64 per second with the default sizes.

Software loads the seconds count and an alarm value through a small write port. It sees the current count on a registered output. Two sticky interrupt flags are raised. The alarm flag goes up one full second after the count was seen equal to the alarm value. The tick flag goes up on every tick. Each flag is dropped by a write to its own acknowledge address.

Top module: `rtc_match_tick`

## Requirements
- R1: After a synchronous reset, the seconds output is 0, both interrupt flags are 0, the prescaler is 0 and the alarm register holds all ones.
- R2: The seconds count rises by one on each 2^DIV_BITS-th cycle that has the slow strobe high, counted from reset or from the last time load. Cycles with the strobe low do not advance the prescaler or the count.
- R3: The tick flag sets on each strobe cycle that wraps the low TICK_BITS bits of the prescaler, which is every 2^TICK_BITS strobes.
- R4: A write to address 0 loads wr_data into the seconds count and clears the prescaler, so that the next increment follows a full 2^DIV_BITS strobes. A load takes precedence over a strobe in the same cycle.
- R5: The seconds count wraps from 0xFFFFFFFF to 0.
- R6: A write to address 1 stores the alarm value. If the count equals the alarm value on a cycle that is not a one-second step, a pending mark is recorded. The alarm flag sets on the next one-second step, which is the step where the count leaves the alarm value.
- R7: A write to address 2 clears the alarm flag, and a write to address 3 clears the tick flag. Neither write changes the other flag or the count.
- R8: If a flag's set condition and its acknowledge write fall in the same cycle, the flag ends that cycle set.
- R9: A write to address 0 or 1 drops any pending alarm mark. If the alarm value is moved away from the count before the next step, no alarm follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_32k | input | 1 | Slow strobe that advances the prescaler |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | Write address: 0 time, 1 alarm, 2 alarm acknowledge, 3 tick acknowledge |
| wr_data | input | 32 | Write data (used by addresses 0 and 1) |
| sec_value | output | 32 | Current seconds count |
| irq_match | output | 1 | Alarm interrupt flag |
| irq_tick | output | 1 | Tick interrupt flag |

## Verification
The hardest case to reach is the alarm timing. The count has to sit on the alarm value for a whole second, and the flag must appear exactly on the following step. A stray pending mark must never produce a flag. The bench reaches these cases with a reduced prescaler (64 strobes per second, tick every 4). It loads the time and alarm directly, then sweeps strobe by strobe through two or three seconds, and the expected flag state is worked out from the strobe count since the load. One sweep acknowledges the tick on every cycle so that the set-over-clear rule is exercised on every tick. Another moves the alarm away in mid-second, and another places the alarm at 0xFFFFFFFF so that it fires across the wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    REG_TIME      = 2'd0,
    REG_ALARM     = 2'd1,
    REG_ALARM_ACK = 2'd2,
    REG_TICK_ACK  = 2'd3
  } reg_sel_e;

  localparam int FLAG_ALARM = 0;
  localparam int FLAG_TICK  = 1;
  localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS  = 15,
  parameter int TICK_BITS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic restart,
  output logic tick_pulse,
  output logic sec_pulse
);
  localparam logic [DIV_BITS-1:0] ALL_ONES = {DIV_BITS{1'b1}};

  logic [DIV_BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (ce)      cnt_q <= cnt_q + 1'b1;
  end

  // a stage "rises" when the lower bits roll over
  assign sec_pulse  = ce && !restart && (cnt_q == ALL_ONES);
  assign tick_pulse = ce && !restart && (&cnt_q[TICK_BITS-1:0]);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce && !restart) |=> $stable(cnt_q));
  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
  // R3
  tick_in_sec_chk: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> tick_pulse);
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  input  logic             alarm_load,
  input  logic [SEC_W-1:0] alarm_val,
  input  logic             sec_pulse,
  output logic [SEC_W-1:0] sec_q,
  output logic             alarm_fire
);
  logic [SEC_W-1:0] alarm_q;
  logic             pending_q;
  logic             equal;

  always_ff @(posedge clk) begin
    if (rst)            sec_q <= '0;
    else if (load)      sec_q <= load_val;
    else if (sec_pulse) sec_q <= sec_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             alarm_q <= '1;
    else if (alarm_load) alarm_q <= alarm_val;
  end

  assign equal = (sec_q == alarm_q);

  always_ff @(posedge clk) begin
    if (rst)                                pending_q <= 1'b0;
    else if (load || alarm_load || sec_pulse) pending_q <= 1'b0;
    else if (equal)                         pending_q <= 1'b1;
  end

  assign alarm_fire = sec_pulse && pending_q;

  // R4
  sec_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (sec_q == $past(load_val)));
  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !load) |=> (sec_q == $past(sec_q) + 1'b1));
  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sec_pulse && !load) |=> $stable(sec_q));
  // R9
  pending_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (load || alarm_load) |=> !pending_q);
endmodule

// File: rtl/rtc_flag.sv
module rtc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> flag_q);
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag_q);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && flag_q) |=> flag_q);
endmodule

// File: rtl/rtc_match_tick.sv
module rtc_match_tick #(
  parameter int DIV_BITS  = 15,
  parameter int TICK_BITS = 9,
  parameter int SEC_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_32k,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [SEC_W-1:0] wr_data,
  output logic [SEC_W-1:0] sec_value,
  output logic             irq_match,
  output logic             irq_tick
);
  import rtc_pkg::*;

  reg_sel_e sel;
  logic     wr_time, wr_alarm, ack_alarm, ack_tick;
  logic     tick_pulse, sec_pulse, alarm_fire;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  assign sel       = reg_sel_e'(wr_addr);
  assign wr_time   = wr_en && (sel == REG_TIME);
  assign wr_alarm  = wr_en && (sel == REG_ALARM);
  assign ack_alarm = wr_en && (sel == REG_ALARM_ACK);
  assign ack_tick  = wr_en && (sel == REG_TICK_ACK);

  rtc_prescaler #(.DIV_BITS(DIV_BITS), .TICK_BITS(TICK_BITS)) u_pre (
    .clk(clk), .rst(rst), .ce(ce_32k), .restart(wr_time),
    .tick_pulse(tick_pulse), .sec_pulse(sec_pulse)
  );

  rtc_seconds #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst),
    .load(wr_time), .load_val(wr_data),
    .alarm_load(wr_alarm), .alarm_val(wr_data),
    .sec_pulse(sec_pulse),
    .sec_q(sec_value), .alarm_fire(alarm_fire)
  );

  assign flag_set[FLAG_ALARM] = alarm_fire;
  assign flag_clr[FLAG_ALARM] = ack_alarm;
  assign flag_set[FLAG_TICK]  = tick_pulse;
  assign flag_clr[FLAG_TICK]  = ack_tick;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rtc_flag u_flag (
      .clk(clk), .rst(rst), .set(flag_set[g]), .clr(flag_clr[g]),
      .flag_q(flag_q[g])
    );
  end

  assign irq_match = flag_q[FLAG_ALARM];
  assign irq_tick  = flag_q[FLAG_TICK];

  // R6
  alarm_on_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_match) |-> $past(sec_pulse));
  // R3
  tick_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_tick) |-> $past(ce_32k));
endmodule

// File: tb/sim_rtc_match_tick.sv
module sim_rtc_match_tick;
  localparam int CLK_P = 10;
  localparam int DIVB  = 6;
  localparam int TICKB = 2;
  localparam int SEC_N  = 1 << DIVB;
  localparam int TICK_N = 1 << TICKB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_32k = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] sec_value;
  logic        irq_match, irq_tick;

  int total = 0;
  int bad = 0;
  int n = 0;
  logic [31:0] base = '0;
  logic exp_tick = 1'b0;
  logic exp_match = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rtc_match_tick #(.DIV_BITS(DIVB), .TICK_BITS(TICKB), .SEC_W(32)) u0 (
    .clk(clk), .rst(rst), .ce_32k(ce_32k), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_value(sec_value), .irq_match(irq_match),
    .irq_tick(irq_tick)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (n=%0d)", req, act, exp, n);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    ce_32k = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    if (a == 2'd0) begin base = d; n = 0; end
    if (a == 2'd2) exp_match = 1'b0;
    if (a == 2'd3) exp_tick = 1'b0;
  endtask

  // gap=0: strobe every cycle; else strobe off when i%gap==0
  task automatic run(input int cycles, input int gap, input bit ack_tick, input int fire_at);
    for (int i = 0; i < cycles; i++) begin
      logic ce_now;
      ce_now = (gap == 0) ? 1'b1 : ((i % gap) != 0);
      ce_32k = ce_now;
      if (ack_tick) begin wr_en = 1'b1; wr_addr = 2'd3; end
      step();
      if (ce_now) begin
        n++;
        if ((n % TICK_N) == 0) exp_tick = 1'b1;
        else if (ack_tick) exp_tick = 1'b0;
        if (fire_at > 0 && n == fire_at) exp_match = 1'b1;
      end else if (ack_tick) exp_tick = 1'b0;
      check("R2/R5 seconds", sec_value, base + 32'(n / SEC_N));
      check(ack_tick ? "R3/R8 tick" : "R3 tick", {31'd0, irq_tick}, {31'd0, exp_tick});
      check("R6 alarm", {31'd0, irq_match}, {31'd0, exp_match});
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state (alarm all ones: no alarm during first sweep)
    check("R1 seconds", sec_value, 32'd0);
    check("R1 irq_match", {31'd0, irq_match}, 32'd0);
    check("R1 irq_tick", {31'd0, irq_tick}, 32'd0);

    // R2 R3 R8: full strobes with tick acknowledge every cycle
    run(3 * SEC_N, 0, 1'b1, 0);
    // R2: gated strobe pattern
    run(200, 3, 1'b0, 0);
    run(100, 0, 1'b0, 0);

    // R7: tick ack leaves count and alarm flag untouched
    wr(2'd3, 32'd0);
    check("R7 tick ack", {31'd0, irq_tick}, 32'd0);
    check("R7 count kept", sec_value, base + 32'(n / SEC_N));

    // R4 R5: load near top, alarm at top, wrap
    wr(2'd1, 32'd5);
    wr(2'd0, 32'hFFFF_FFFE);
    check("R4 load", sec_value, 32'hFFFF_FFFE);
    run(2 * SEC_N, 0, 1'b1, 0);
    check("R5 wrap", sec_value, 32'd0);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFF);
    run(2 * SEC_N, 0, 1'b1, SEC_N);
    check("R5/R6 alarm across wrap", {31'd0, irq_match}, 32'd1);

    // R7: alarm ack clears only the alarm flag
    run(3, 0, 1'b0, 0);
    wr(2'd2, 32'd0);
    check("R7 alarm ack", {31'd0, irq_match}, 32'd0);
    check("R7 tick kept", {31'd0, irq_tick}, {31'd0, exp_tick});

    // R6: alarm two seconds ahead
    wr(2'd0, 32'd20);
    wr(2'd1, 32'd22);
    run(3 * SEC_N + 5, 0, 1'b0, 3 * SEC_N);
    wr(2'd2, 32'd0);

    // R4: load with strobe in same cycle -> full second after
    ce_32k = 1'b1;
    wr(2'd0, 32'd40);
    run(SEC_N - 1, 0, 1'b0, 0);
    check("R4 full second", sec_value, 32'd40);
    run(1, 0, 1'b0, 0);
    check("R4 step", sec_value, 32'd41);

    // R9: alarm equal then moved away before step -> no alarm
    wr(2'd0, 32'd30);
    wr(2'd1, 32'd30);
    run(10, 0, 1'b0, 0);
    wr(2'd1, 32'd99);
    run(2 * SEC_N, 0, 1'b0, 0);
    check("R9 no alarm", {31'd0, irq_match}, 32'd0);

    // R8: alarm ack in the cycle the alarm fires
    wr(2'd1, 32'd50);
    wr(2'd0, 32'd50);
    run(SEC_N - 1, 0, 1'b0, 0);
    ce_32k = 1'b1; wr_en = 1'b1; wr_addr = 2'd2;
    step();
    check("R8 alarm set wins", {31'd0, irq_match}, 32'd1);
    check("R8 count", sec_value, 32'd51);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule